// File: doc/BRIEF.md
# Octal Driver Fault Diagnosis Controller

This block sits on the host side of a serial link to an eight-channel low-side power driver. It owns the link's chip-select, serial clock and host-to-device data lines, and reads back the device's data line. One check runs like this: `start_i` captures an eight-bit control word and the block shifts it into the driver. It then keeps the driver deselected for a settle interval so that the outputs can reach their final state. Then it shifts the identical word in a second time, and while doing so it collects the eight status bits that the driver returns. The status returned in the first transfer is thrown away.

The driver works with inverted command polarity: a 0 bit turns a channel on and a 1 bit turns it off. Its status bit for a channel reads 1 when that output pin is high. From this, a channel that was commanded on but reads back high is reported as shorted or overloaded, and a channel that was commanded off but reads back low is reported as an open load. Both masks are presented together with a one-cycle completion pulse. The serial clock half period, the select-to-clock spacings and the settle interval are all counted in system clocks and set by parameters. At the defaults, with a 50 MHz system clock, the serial clock runs at about 1.92 MHz and the settle interval is 160 µs.

Top module: `spi_fault_checker`

## Requirements
- R1: One accepted start produces exactly two chip-select frames carrying the same word. Chip-select stays high for at least SETTLE_CYC system clocks between the end of the first frame and the start of the second.
- R2: In each frame the word goes out most significant bit (channel 7) first on `mosi_o`. `mosi_o` changes only in the cycle in which `sclk_o` rises, so it is stable across every falling edge.
- R3: `miso_i` is sampled at the end of each high phase of `sclk_o`. Only the eight bits gathered during the second frame are used for the diagnosis.
- R4: `sclk_o` is low whenever `cs_no` changes level.
- R5: Each high phase and each low phase of `sclk_o` within a frame lasts at least HALF_CYC system clocks.
- R6: The first rising edge of `sclk_o` comes at least LEAD_CYC clocks after `cs_no` falls. `cs_no` rises at least LAG_CYC clocks after the last falling edge of `sclk_o`.
- R7: Bit i of `short_mask_o` is 1 exactly when the command bit i was 0 and the status bit i returned in the second frame is 1.
- R8: Bit i of `open_mask_o` is 1 exactly when the command bit i was 1 and the status bit i returned in the second frame is 0.
- R9: A start that arrives while `busy_o` is high is ignored. It causes no extra frame and does not change the word being sent.
- R10: `done_o` is high for exactly one cycle per check. The masks change only in that cycle and otherwise hold their value.
- R11: While reset is held and right after it is released: `cs_no`=1, `sclk_o`=0, `busy_o`=0, `done_o`=0, and both masks are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a check with `cmd_i` (single cycle) |
| cmd_i | input | DATA_W | Control word; bit value 0 = channel on, 1 = off |
| cs_no | output | 1 | Driver chip select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to driver |
| miso_i | input | 1 | Serial status data from driver |
| busy_o | output | 1 | Check in progress |
| done_o | output | 1 | One-cycle completion pulse |
| short_mask_o | output | DATA_W | Per-channel short or overload flags |
| open_mask_o | output | DATA_W | Per-channel open-load flags |

## Verification
A sequencer stuck in the wrong phase shows at the ports as a missing or extra chip-select frame, or as a settle gap that is too short, within one check (about 8,500 clocks). A fault in the frame engine's counters appears on the next serial clock edge, as a shortened phase or a clock edge at a select transition. A bit-order fault or a wrongly captured status word appears in the masks at the next `done_o`. The first check after reset is arranged so that the discarded status word differs from the one that is kept. Using the wrong word therefore flips every mask bit at once.

// File: rtl/spi_chk_pkg.sv
package spi_chk_pkg;
  typedef enum logic [2:0] {FR_IDLE, FR_LEAD, FR_HIGH, FR_LOW, FR_LAG} frame_st_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_TX1, SQ_WAIT, SQ_TX2} seq_st_e;
endpackage

// File: rtl/spi_chk_frame.sv
module spi_chk_frame
  import spi_chk_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_CYC = 13,
  parameter int LEAD_CYC = 4,
  parameter int LAG_CYC  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              miso_i,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int TMAX  = (HALF_CYC > LEAD_CYC) ? ((HALF_CYC > LAG_CYC) ? HALF_CYC : LAG_CYC)
                                                : ((LEAD_CYC > LAG_CYC) ? LEAD_CYC : LAG_CYC);
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  frame_st_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] tx_q, rx_q;
  logic              cs_nq, sclk_q, mosi_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FR_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      cs_nq  <= 1'b1;
      sclk_q <= 1'b0;
      mosi_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        FR_IDLE: if (go_i) begin
          tx_q  <= data_i;
          cs_nq <= 1'b0;
          bit_q <= '0;
          cnt_q <= CNT_W'(LEAD_CYC - 1);
          st_q  <= FR_LEAD;
        end
        FR_LEAD: if (cnt_q == '0) begin
          sclk_q <= 1'b1;
          mosi_q <= tx_q[DATA_W-1];
          cnt_q  <= CNT_W'(HALF_CYC - 1);
          st_q   <= FR_HIGH;
        end else cnt_q <= cnt_q - 1'b1;
        FR_HIGH: if (cnt_q == '0) begin
          // device drives new status after rising edge; take it late in the high phase
          rx_q   <= {rx_q[DATA_W-2:0], miso_i};
          sclk_q <= 1'b0;
          cnt_q  <= CNT_W'(HALF_CYC - 1);
          st_q   <= FR_LOW;
        end else cnt_q <= cnt_q - 1'b1;
        FR_LOW: if (cnt_q == '0) begin
          if (bit_q == BIT_W'(DATA_W - 1)) begin
            cnt_q <= CNT_W'(LAG_CYC - 1);
            st_q  <= FR_LAG;
          end else begin
            bit_q  <= bit_q + 1'b1;
            tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
            mosi_q <= tx_q[DATA_W-2];
            sclk_q <= 1'b1;
            cnt_q  <= CNT_W'(HALF_CYC - 1);
            st_q   <= FR_HIGH;
          end
        end else cnt_q <= cnt_q - 1'b1;
        FR_LAG: if (cnt_q == '0) begin
          cs_nq  <= 1'b1;
          done_q <= 1'b1;
          st_q   <= FR_IDLE;
        end else cnt_q <= cnt_q - 1'b1;
        default: st_q <= FR_IDLE;
      endcase
    end
  end

  assign cs_no  = cs_nq;
  assign sclk_o = sclk_q;
  assign mosi_o = mosi_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;

  // checker: cycles since the last level change of select and clock
  localparam int AGE_W = $clog2(TMAX + 2);
  logic             cs_p, sclk_p;
  logic [AGE_W-1:0] cs_age, sclk_age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_p     <= 1'b1;
      sclk_p   <= 1'b0;
      cs_age   <= AGE_W'(TMAX);
      sclk_age <= AGE_W'(TMAX);
    end else begin
      cs_p   <= cs_nq;
      sclk_p <= sclk_q;
      if (cs_nq != cs_p) cs_age <= AGE_W'(1);
      else if (cs_age < AGE_W'(TMAX)) cs_age <= cs_age + 1'b1;
      if (sclk_q != sclk_p) sclk_age <= AGE_W'(1);
      else if (sclk_age < AGE_W'(TMAX)) sclk_age <= sclk_age + 1'b1;
    end
  end

  a_r4_sclk_low_at_cs_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_nq != cs_p) |-> !sclk_q);
  a_r5_half_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_q != sclk_p) |-> (sclk_age >= AGE_W'(HALF_CYC)));
  a_r6_lead_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_q && !sclk_p) |-> (cs_age >= AGE_W'(LEAD_CYC)));
  a_r6_lag_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_nq && !cs_p) |-> (sclk_age >= AGE_W'(LAG_CYC)));
endmodule

// File: rtl/spi_chk_settle.sv
module spi_chk_settle #(
  parameter int SETTLE_CYC = 8000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expire_o
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= CNT_W'(SETTLE_CYC - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = run_q && (cnt_q == '0);

  a_r1_expire_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);
endmodule

// File: rtl/spi_chk_classify.sv
module spi_chk_classify #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] sent_i,
  input  logic [DATA_W-1:0] back_i,
  output logic [DATA_W-1:0] short_o,
  output logic [DATA_W-1:0] open_o
);
  // sent 0 = on: reading high means the switch could not pull down
  for (genvar i = 0; i < DATA_W; i++) begin : g_ch
    assign short_o[i] = !sent_i[i] &&  back_i[i];
    assign open_o[i]  =  sent_i[i] && !back_i[i];
  end
endmodule

// File: rtl/spi_fault_checker.sv
module spi_fault_checker
  import spi_chk_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int HALF_CYC   = 13,
  parameter int LEAD_CYC   = 4,
  parameter int LAG_CYC    = 4,
  parameter int SETTLE_CYC = 8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] cmd_i,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] short_mask_o,
  output logic [DATA_W-1:0] open_mask_o
);
  seq_st_e           st_q;
  logic [DATA_W-1:0] cmd_q, short_q, open_q;
  logic              done_q;
  logic              fr_go, fr_done, tmr_load, tmr_exp;
  logic [DATA_W-1:0] fr_data, fr_rx, cls_short, cls_open;

  assign fr_go    = ((st_q == SQ_IDLE) && start_i) || ((st_q == SQ_WAIT) && tmr_exp);
  assign fr_data  = (st_q == SQ_IDLE) ? cmd_i : cmd_q;
  assign tmr_load = (st_q == SQ_TX1) && fr_done;

  spi_chk_frame #(
    .DATA_W(DATA_W), .HALF_CYC(HALF_CYC), .LEAD_CYC(LEAD_CYC), .LAG_CYC(LAG_CYC)
  ) u_frame (
    .clk_i, .rst_ni,
    .go_i   (fr_go),
    .data_i (fr_data),
    .miso_i,
    .cs_no,
    .sclk_o,
    .mosi_o,
    .done_o (fr_done),
    .rx_o   (fr_rx)
  );

  spi_chk_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i, .rst_ni,
    .load_i   (tmr_load),
    .expire_o (tmr_exp)
  );

  spi_chk_classify #(.DATA_W(DATA_W)) u_cls (
    .sent_i  (cmd_q),
    .back_i  (fr_rx),
    .short_o (cls_short),
    .open_o  (cls_open)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SQ_IDLE;
      cmd_q   <= '0;
      short_q <= '0;
      open_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        SQ_IDLE: if (start_i) begin
          cmd_q <= cmd_i;
          st_q  <= SQ_TX1;
        end
        SQ_TX1:  if (fr_done) st_q <= SQ_WAIT;  // first status word dropped
        SQ_WAIT: if (tmr_exp) st_q <= SQ_TX2;
        SQ_TX2:  if (fr_done) begin
          short_q <= cls_short;
          open_q  <= cls_open;
          done_q  <= 1'b1;
          st_q    <= SQ_IDLE;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q != SQ_IDLE);
  assign done_o       = done_q;
  assign short_mask_o = short_q;
  assign open_mask_o  = open_q;

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((short_mask_o != $past(short_mask_o)) || (open_mask_o != $past(open_mask_o))) |-> done_o);
  a_r9_cmd_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(cmd_q));
  a_r1_no_frame_in_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_WAIT) |-> cs_no);
endmodule

// File: tb/spi_fault_checker_tb_top.sv
module spi_fault_checker_tb_top;
  localparam int HALF   = 13;
  localparam int LEAD   = 4;
  localparam int LAG    = 4;
  localparam int SETTLE = 8000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] cmd = 8'h00;
  logic       cs_no, sclk_o, mosi_o, busy_o, done_o;
  logic [7:0] short_m, open_m;

  // device model state
  logic [7:0] dev_sh = 8'hFF;
  logic [7:0] dev_latch = 8'hFF;   // all channels off after power-up
  logic       dev_so = 1'b0;
  logic [7:0] short_f = 8'h00, open_f = 8'h00;
  logic       m_cs_p = 1'b1, m_sclk_p = 1'b0;

  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  spi_fault_checker #(
    .DATA_W(8), .HALF_CYC(HALF), .LEAD_CYC(LEAD), .LAG_CYC(LAG), .SETTLE_CYC(SETTLE)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd),
    .cs_no(cs_no), .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(dev_so),
    .busy_o(busy_o), .done_o(done_o), .short_mask_o(short_m), .open_mask_o(open_m)
  );

  function automatic logic [7:0] pin_status(input logic [7:0] lat, input logic [7:0] sh, input logic [7:0] op);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = lat[i] ? !op[i] : sh[i];
    return r;
  endfunction

  always @(cs_no or sclk_o) begin
    if (cs_no !== m_cs_p) begin
      if (cs_no === 1'b0) dev_sh = pin_status(dev_latch, short_f, open_f);
      else if (cs_no === 1'b1) dev_latch = dev_sh;
    end else if (sclk_o !== m_sclk_p && cs_no === 1'b0) begin
      if (sclk_o) dev_so = dev_sh[7];
      else dev_sh = {dev_sh[6:0], mosi_o};
    end
    m_cs_p = cs_no;
    m_sclk_p = sclk_o;
  end

  // link timing monitor, sampled on falling system clock
  int bad_edge = 0, bad_half = 0, bad_lead = 0, bad_lag = 0, bad_si = 0;
  int frames = 0, last_gap = 0;
  int cs_run = 100000, sclk_run = 100000;
  logic n_cs = 1'b1, n_sclk = 1'b0, n_mosi = 1'b1;

  always @(negedge clk) if (rst_n) begin
    if (cs_no != n_cs) begin
      if (sclk_o) bad_edge++;
      if (!cs_no) begin frames++; last_gap = cs_run; end
      else if (sclk_run < LAG) bad_lag++;
      cs_run = 1;
    end else if (cs_run < 100000) cs_run++;
    if (sclk_o != n_sclk) begin
      if (sclk_run < HALF) bad_half++;
      if (sclk_o && cs_run < LEAD) bad_lead++;
      sclk_run = 1;
    end else if (sclk_run < 100000) sclk_run++;
    if (!cs_no && (mosi_o != n_mosi) && !sclk_o && !n_sclk) bad_si++;
    n_cs = cs_no; n_sclk = sclk_o; n_mosi = mosi_o;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // one full check; verifies link rules, masks and the pulse
  task automatic run_check(input logic [7:0] c, input logic [7:0] sf, input logic [7:0] of);
    int f0, e0, h0, l0, g0, s0;
    logic [7:0] exp_short, exp_open;
    short_f = sf; open_f = of;
    f0 = frames; e0 = bad_edge; h0 = bad_half; l0 = bad_lead + bad_lag; s0 = bad_si;
    exp_short = ~c & pin_status(c, sf, of);
    exp_open  =  c & ~pin_status(c, sf, of);
    @(negedge clk); cmd = c; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done_o) @(negedge clk);
    chk("R7", "short mask", short_m, exp_short);
    chk("R8", "open mask", open_m, exp_open);
    chk("R1", "frame count", frames - f0, 2);
    g0 = (last_gap >= SETTLE) ? 1 : 0;
    chk("R1", "settle gap ok", g0, 1);
    chk("R2", "word latched by device", dev_latch, c);
    chk("R2", "data moved with clock low", bad_si - s0, 0);
    chk("R4", "clock high at select edge", bad_edge - e0, 0);
    chk("R5", "short clock phase", bad_half - h0, 0);
    chk("R6", "lead/lag violation", bad_lead + bad_lag - l0, 0);
    @(negedge clk);
    chk("R10", "done width", done_o, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11", "cs in reset", cs_no, 1);
    chk("R11", "sclk in reset", sclk_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "busy after reset", busy_o, 0);
    chk("R11", "done after reset", done_o, 0);
    chk("R11", "masks after reset", {short_m, open_m}, 16'h0);
  endtask

  // device was all off: first status word reads FF, second 00
  task automatic t_first_discarded;
    run_check(8'h00, 8'h00, 8'h00);
    chk("R3", "all-on clean gives no short", short_m, 8'h00);
  endtask

  task automatic t_shorts;
    run_check(8'h0F, 8'hFF, 8'h00);
  endtask

  task automatic t_opens;
    run_check(8'hA5, 8'h00, 8'hFF);
  endtask

  task automatic t_mixed;
    run_check(8'h3C, 8'h81, 8'h24);
    chk("R7", "mixed short", short_m, 8'h81);
    chk("R8", "mixed open", open_m, 8'h24);
  endtask

  task automatic t_busy_ignore;
    int f0;
    short_f = 8'hFF; open_f = 8'h00;
    f0 = frames;
    @(negedge clk); cmd = 8'h5A; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (600) @(negedge clk);
    chk("R9", "busy during settle", busy_o, 1);
    cmd = 8'h00; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done_o) @(negedge clk);
    chk("R9", "short mask uses first word", short_m, 8'hA5);
    chk("R9", "device word", dev_latch, 8'h5A);
    repeat (400) @(negedge clk);
    chk("R9", "no extra frames", frames - f0, 2);
    chk("R9", "idle after check", busy_o, 0);
  endtask

  task automatic t_hold;
    short_f = 8'h00; open_f = 8'hFF;
    repeat (300) @(negedge clk);
    chk("R10", "short mask held", short_m, 8'hA5);
    chk("R10", "open mask held", open_m, 8'h00);
    chk("R10", "no done while idle", done_o, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_first_discarded();
    t_shorts();
    t_opens();
    t_mixed();
    t_busy_ignore();
    t_hold();
    summary();
    $finish;
  end
endmodule